// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block turns one operand specifier of a small 16-bit microcontroller into either a 20-bit memory address or a direct value. Each request carries an addressing-mode code, a base-register selector, a 20-bit field, an immediate-size code and a word/byte flag. The request also carries the current contents of the two address registers, the static base, the frame base and the stack pointer. One cycle after a request is accepted, the block presents the result together with two indications. The first says whether the operand lives in memory. The second flags a word access that lands on an odd byte address.

Each mode allows only certain base registers. Register-relative and static-base-relative modes add an unsigned 16-bit offset. Frame/stack-relative mode adds a signed 8-bit offset. Any sum wraps modulo 2^20. A mode that is combined with a base register it does not allow, or a reserved code, gives a one-cycle illegal pulse in place of a valid result. The memory access itself, instruction fetch and decode all happen outside this block.

Top module: `eag_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_illegal, out_mem, out_misalign and out_value are all zero.
- R2: The outputs change only after a request, and a request raised with in_valid high is answered exactly one cycle later. After a cycle with in_valid low, both out_valid and out_illegal are low.
- R3: Immediate mode (mode 0) puts the literal on out_value with out_mem low. The literal is in_fld masked to 8 bits for in_imm_sz 0, to 16 bits for 1, and to all 20 bits for 2. in_imm_sz 3 is illegal. The base selector is ignored.
- R4: Register-direct mode (mode 1) gives out_valid high, out_mem low and out_value zero, for any base selector.
- R5: Absolute mode (mode 2) puts in_fld on out_value as the address, with out_mem high. The base selector is ignored.
- R6: Indirect mode (mode 3) accepts only base selector 0 (A0) or 1 (A1), and its address is that register zero-extended to 20 bits.
- R7: Address-register-relative mode (mode 4) accepts only A0 or A1, and its address is (base + in_fld[15:0]) mod 2^20 with the offset unsigned.
- R8: Static-base-relative mode (mode 5) accepts only selector 2 (SB), and its address is (SB + in_fld[15:0]) mod 2^20.
- R9: Frame/stack-relative mode (mode 6) accepts only selector 3 (FB) or 4 (SP). Its address is (base + sign-extended in_fld[7:0]) mod 2^20, so an offset of 80h subtracts 128, and in_fld[19:8] is ignored.
- R10: An illegal request gives out_illegal high with out_valid, out_mem, out_misalign and out_value all low. Illegal requests are mode 7, immediate size 3, and any selector a mode does not allow, including selectors 5 to 7.
- R11: out_misalign is high exactly when the result is valid, out_mem is high, in_word was high, and out_value bit 0 is 1. Words sit at even byte addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 3 | Addressing-mode code |
| in_base | input | 3 | Base-register selector |
| in_imm_sz | input | 2 | Immediate width code |
| in_word | input | 1 | Operand is a 16-bit word |
| in_fld | input | 20 | Literal, absolute address or displacement |
| reg_a0 | input | 16 | Address register 0 |
| reg_a1 | input | 16 | Address register 1 |
| reg_sb | input | 16 | Static base |
| reg_fb | input | 16 | Frame base |
| reg_sp | input | 16 | Stack pointer |
| out_valid | output | 1 | Result valid |
| out_value | output | 20 | Address or immediate value |
| out_mem | output | 1 | Operand needs a memory access |
| out_illegal | output | 1 | Mode/base combination not permitted |
| out_misalign | output | 1 | Word access at an odd address |

## Verification
The bench builds the block with its default widths: 20-bit addresses, 16-bit registers, a 16-bit unsigned offset and an 8-bit signed offset. With these widths a 16-bit base plus a 16-bit offset carries into bit 16, and a small base plus a negative offset wraps through 2^20. Both corners are driven on purpose, alongside random requests that cover every mode against every selector.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    M_IMM  = 3'd0,
    M_REG  = 3'd1,
    M_ABS  = 3'd2,
    M_IND  = 3'd3,
    M_AREL = 3'd4,
    M_SREL = 3'd5,
    M_FREL = 3'd6,
    M_RSV  = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    B_A0 = 3'd0,
    B_A1 = 3'd1,
    B_SB = 3'd2,
    B_FB = 3'd3,
    B_SP = 3'd4
  } base_e;

  localparam int NBASE = 5;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic legal;
    logic need_mem;
    logic use_base;
    logic use_disp;
    logic disp_sgn;
    logic is_imm;
  } ctl_t;
endpackage

// File: rtl/eag_rule.sv
module eag_rule
  import eag_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [2:0] base_sel,
  input  logic [1:0] imm_sz,
  output ctl_t       ctl
);
  logic sel_addr;
  logic sel_sb;
  logic sel_frame;

  assign sel_addr  = (base_sel == B_A0) || (base_sel == B_A1);
  assign sel_sb    = (base_sel == B_SB);
  assign sel_frame = (base_sel == B_FB) || (base_sel == B_SP);

  always_comb begin
    ctl = '0;
    unique case (mode)
      M_IMM: begin
        ctl.is_imm = 1'b1;
        ctl.legal  = (imm_sz != 2'd3);
      end
      M_REG: ctl.legal = 1'b1;
      M_ABS: begin
        ctl.legal    = 1'b1;
        ctl.need_mem = 1'b1;
      end
      M_IND: begin
        ctl.legal    = sel_addr;
        ctl.need_mem = 1'b1;
        ctl.use_base = 1'b1;
      end
      M_AREL: begin
        ctl.legal    = sel_addr;
        ctl.need_mem = 1'b1;
        ctl.use_base = 1'b1;
        ctl.use_disp = 1'b1;
      end
      M_SREL: begin
        ctl.legal    = sel_sb;
        ctl.need_mem = 1'b1;
        ctl.use_base = 1'b1;
        ctl.use_disp = 1'b1;
      end
      M_FREL: begin
        ctl.legal    = sel_frame;
        ctl.need_mem = 1'b1;
        ctl.use_base = 1'b1;
        ctl.use_disp = 1'b1;
        ctl.disp_sgn = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/eag_disp.sv
module eag_disp #(
  parameter int ADDR_W  = 20,
  parameter int UDISP_W = 16,
  parameter int SDISP_W = 8
) (
  input  logic [UDISP_W-1:0] udisp,
  input  logic [SDISP_W-1:0] sdisp,
  input  logic               sgn,
  output logic [ADDR_W-1:0]  ext
);
  localparam int UPAD = ADDR_W - UDISP_W;
  localparam int SPAD = ADDR_W - SDISP_W;

  logic [ADDR_W-1:0] u_ext;
  logic [ADDR_W-1:0] s_ext;

  assign u_ext = {{UPAD{1'b0}}, udisp};
  assign s_ext = {{SPAD{sdisp[SDISP_W-1]}}, sdisp};
  assign ext   = sgn ? s_ext : u_ext;
endmodule

// File: rtl/eag_basemux.sv
module eag_basemux #(
  parameter int ADDR_W = 20,
  parameter int REG_W  = 16,
  parameter int NB     = 5,
  parameter int SEL_W  = 3
) (
  input  logic [NB*REG_W-1:0] regs_flat,
  input  logic [SEL_W-1:0]    sel,
  output logic [ADDR_W-1:0]   base
);
  localparam int PAD = ADDR_W - REG_W;

  logic [ADDR_W-1:0] lane [NB];
  logic [NB-1:0]     hit;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign hit[i]  = (sel == SEL_W'(i));
    assign lane[i] = hit[i] ? {{PAD{1'b0}}, regs_flat[i*REG_W +: REG_W]} : '0;
  end

  always_comb begin
    base = '0;
    for (int j = 0; j < NB; j++) base = base | lane[j];
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int REG_W   = 16,
  parameter int UDISP_W = 16,
  parameter int SDISP_W = 8,
  parameter int IMM_S_W = 8,
  parameter int IMM_M_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_mode,
  input  logic [2:0]        in_base,
  input  logic [1:0]        in_imm_sz,
  input  logic              in_word,
  input  logic [ADDR_W-1:0] in_fld,
  input  logic [REG_W-1:0]  reg_a0,
  input  logic [REG_W-1:0]  reg_a1,
  input  logic [REG_W-1:0]  reg_sb,
  input  logic [REG_W-1:0]  reg_fb,
  input  logic [REG_W-1:0]  reg_sp,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_value,
  output logic              out_mem,
  output logic              out_illegal,
  output logic              out_misalign
);
  localparam int SPAD = ADDR_W - IMM_S_W;
  localparam int MPAD = ADDR_W - IMM_M_W;

  ctl_t              ctl;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base_val;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] imm_val;
  logic [ADDR_W-1:0] nxt_value;
  logic [NBASE*REG_W-1:0] regs_flat;

  assign regs_flat = {reg_sp, reg_fb, reg_sb, reg_a1, reg_a0};

  eag_rule u_rule (
    .mode     (in_mode),
    .base_sel (in_base),
    .imm_sz   (in_imm_sz),
    .ctl      (ctl)
  );

  eag_disp #(.ADDR_W(ADDR_W), .UDISP_W(UDISP_W), .SDISP_W(SDISP_W)) u_disp (
    .udisp (in_fld[UDISP_W-1:0]),
    .sdisp (in_fld[SDISP_W-1:0]),
    .sgn   (ctl.disp_sgn),
    .ext   (disp_ext)
  );

  eag_basemux #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NB(NBASE), .SEL_W(SEL_W)) u_bmux (
    .regs_flat (regs_flat),
    .sel       (in_base),
    .base      (base_val)
  );

  assign sum = base_val + (ctl.use_disp ? disp_ext : '0);

  always_comb begin
    unique case (in_imm_sz)
      2'd0:    imm_val = {{SPAD{1'b0}}, in_fld[IMM_S_W-1:0]};
      2'd1:    imm_val = {{MPAD{1'b0}}, in_fld[IMM_M_W-1:0]};
      default: imm_val = in_fld;
    endcase
  end

  always_comb begin
    if (!ctl.legal)          nxt_value = '0;
    else if (ctl.is_imm)     nxt_value = imm_val;
    else if (ctl.use_base)   nxt_value = sum;
    else if (ctl.need_mem)   nxt_value = in_fld;
    else                     nxt_value = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_value    <= '0;
      out_mem      <= 1'b0;
      out_illegal  <= 1'b0;
      out_misalign <= 1'b0;
    end else if (in_valid) begin
      out_valid    <= ctl.legal;
      out_value    <= nxt_value;
      out_mem      <= ctl.legal & ctl.need_mem;
      out_illegal  <= ~ctl.legal;
      out_misalign <= ctl.legal & ctl.need_mem & in_word & nxt_value[0];
    end else begin
      out_valid    <= 1'b0;
      out_value    <= '0;
      out_mem      <= 1'b0;
      out_illegal  <= 1'b0;
      out_misalign <= 1'b0;
    end
  end
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int ADDR_W = 20,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_mode,
  input logic [2:0]        in_base,
  input logic [1:0]        in_imm_sz,
  input logic [REG_W-1:0]  reg_a0,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_value,
  input logic              out_mem,
  input logic              out_illegal,
  input logic              out_misalign
);
  AST_ILLEGAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_valid && !out_mem && !out_misalign); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_illegal); // R2
  AST_MISALIGN_ODD: assert property (@(posedge clk) disable iff (rst)
    out_misalign |-> out_valid && out_mem && out_value[0]); // R11
  AST_IMM_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_mode == 3'd0 && in_imm_sz != 2'd3 |=> out_valid && !out_mem); // R3
  AST_FRAME_BASE_ONLY: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_mode == 3'd6 && in_base < 3'd3 |=> out_illegal); // R9
  AST_IND_A0: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_mode == 3'd3 && in_base == 3'd0 |=>
      out_valid && out_value == ADDR_W'($past(reg_a0))); // R6
endmodule

bind eag_top eag_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
  .in_base(in_base), .in_imm_sz(in_imm_sz), .reg_a0(reg_a0),
  .out_valid(out_valid), .out_value(out_value), .out_mem(out_mem),
  .out_illegal(out_illegal), .out_misalign(out_misalign)
);

// File: tb/sim_eag_top.sv
module sim_eag_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_mode = '0;
  logic [2:0]  in_base = '0;
  logic [1:0]  in_imm_sz = '0;
  logic        in_word = 1'b0;
  logic [19:0] in_fld = '0;
  logic [15:0] reg_a0 = '0, reg_a1 = '0, reg_sb = '0, reg_fb = '0, reg_sp = '0;
  logic        out_valid, out_mem, out_illegal, out_misalign;
  logic [19:0] out_value;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit v; bit ill; bit mem; bit mis; int val; string req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eag_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_base(in_base), .in_imm_sz(in_imm_sz), .in_word(in_word),
    .in_fld(in_fld), .reg_a0(reg_a0), .reg_a1(reg_a1), .reg_sb(reg_sb),
    .reg_fb(reg_fb), .reg_sp(reg_sp), .out_valid(out_valid),
    .out_value(out_value), .out_mem(out_mem), .out_illegal(out_illegal),
    .out_misalign(out_misalign)
  );

  function automatic exp_t model(bit v, int m, int b, int sz, bit w, int f,
                                 int a0, int a1, int sb, int fb, int sp);
    exp_t e;
    int base;
    int sd;
    bit ok;
    e.v = 0; e.ill = 0; e.mem = 0; e.mis = 0; e.val = 0; e.req = "R2";
    if (!v) return e;
    base = (b == 0) ? a0 : (b == 1) ? a1 : (b == 2) ? sb : (b == 3) ? fb : (b == 4) ? sp : 0;
    sd = f & 8'hFF;
    if (sd >= 128) sd = sd - 256;
    ok = 0;
    case (m)
      0: begin ok = (sz != 3); e.req = "R3";
           e.val = (sz == 0) ? (f & 'hFF) : (sz == 1) ? (f & 'hFFFF) : f; end
      1: begin ok = 1; e.req = "R4"; end
      2: begin ok = 1; e.mem = 1; e.val = f; e.req = "R5"; end
      3: begin ok = (b < 2); e.mem = 1; e.val = base; e.req = "R6"; end
      4: begin ok = (b < 2); e.mem = 1; e.val = (base + (f & 'hFFFF)) & 'hFFFFF; e.req = "R7"; end
      5: begin ok = (b == 2); e.mem = 1; e.val = (base + (f & 'hFFFF)) & 'hFFFFF; e.req = "R8"; end
      6: begin ok = (b == 3 || b == 4); e.mem = 1; e.val = (base + sd) & 'hFFFFF; e.req = "R9"; end
      default: begin ok = 0; e.req = "R10"; end
    endcase
    if (!ok) begin
      e.ill = 1; e.mem = 0; e.val = 0;
      if (m != 7 && e.req != "R3") e.req = {e.req, "/R10"}; else e.req = "R10";
      return e;
    end
    e.v = 1;
    e.mis = e.mem && w && (e.val % 2 == 1);
    if (e.mis) e.req = {e.req, "/R11"};
    return e;
  endfunction

  task automatic cmp(exp_t e);
    checks++;
    if (out_valid !== e.v || out_illegal !== e.ill || out_mem !== e.mem ||
        out_misalign !== e.mis || int'(out_value) !== e.val) begin
      bad++;
      $display("FAIL %s: got v=%0b ill=%0b mem=%0b mis=%0b val=%05h exp v=%0b ill=%0b mem=%0b mis=%0b val=%05h",
               e.req, out_valid, out_illegal, out_mem, out_misalign, out_value,
               e.v, e.ill, e.mem, e.mis, e.val[19:0]);
    end
  endtask

  task automatic req(bit v, int m, int b, int sz, bit w, int f);
    @(negedge clk);
    if (q.size() > 0) cmp(q.pop_front());
    in_valid = v; in_mode = 3'(m); in_base = 3'(b); in_imm_sz = 2'(sz);
    in_word = w; in_fld = 20'(f);
    q.push_back(model(v, m, b, sz, w, f, reg_a0, reg_a1, reg_sb, reg_fb, reg_sp));
  endtask

  task automatic set_regs(int a0, int a1, int sb, int fb, int sp);
    reg_a0 = 16'(a0); reg_a1 = 16'(a1); reg_sb = 16'(sb); reg_fb = 16'(fb); reg_sp = 16'(sp);
  endtask

  initial begin
    exp_t z;
    z.v = 0; z.ill = 0; z.mem = 0; z.mis = 0; z.val = 0; z.req = "R1";
    set_regs('h1110, 'hFFFF, 'h150E, 'h0100, 'h0000);
    repeat (3) @(negedge clk);
    cmp(z);                                   // R1 during reset
    in_valid = 1; in_mode = 3'd2; in_fld = 20'h12345;
    @(negedge clk);
    cmp(z);                                   // R1 still in reset
    rst = 0; in_valid = 0;
    @(negedge clk);
    cmp(z);                                   // R1 first cycle after reset
    // R3 immediate sizes, selector ignored
    req(1, 0, 7, 0, 1, 'hABCDE);
    req(1, 0, 2, 1, 0, 'hABCDE);
    req(1, 0, 0, 2, 1, 'hABCDE);
    req(1, 0, 3, 3, 0, 'h00001);              // R10 size 3
    // R4 register direct
    req(1, 1, 6, 0, 1, 'h55555);
    // R5 absolute, odd word -> R11
    req(1, 2, 5, 0, 1, 'h0213B);
    req(1, 2, 1, 0, 0, 'h0213B);
    // R6 indirect
    req(1, 3, 0, 0, 0, 0);
    req(1, 3, 1, 0, 1, 0);                    // FFFF odd word -> R11
    req(1, 3, 2, 0, 0, 0);                    // R10
    // R7 relative with carry into bit 16
    req(1, 4, 1, 0, 0, 'hFFFF);
    req(1, 4, 0, 0, 1, 4);
    req(1, 4, 4, 0, 0, 4);                    // R10
    // R8 static base
    req(1, 5, 2, 0, 1, 2);
    req(1, 5, 0, 0, 0, 2);                    // R10
    // R9 signed offsets, high bits ignored, wrap below zero
    req(1, 6, 3, 0, 1, 'hFFF80);
    req(1, 6, 3, 0, 0, 'h0007F);
    req(1, 6, 4, 0, 0, 'hFFFFF);              // SP=0, -1 -> FFFFF
    req(1, 6, 1, 0, 0, 2);                    // R10
    req(1, 6, 5, 0, 0, 2);                    // R10 selector out of range
    req(1, 7, 0, 0, 0, 0);                    // R10 reserved mode
    // R2 idle gaps
    req(0, 2, 0, 0, 0, 'h12345);
    req(1, 2, 0, 0, 0, 'h00010);
    req(0, 6, 1, 3, 1, 'hFFFFF);
    // random sweep
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (q.size() > 0) cmp(q.pop_front());
      set_regs($urandom, $urandom, $urandom, $urandom, (i % 7 == 0) ? 0 : $urandom);
      in_valid = ($urandom % 5) != 0; in_mode = 3'($urandom); in_base = 3'($urandom);
      in_imm_sz = 2'($urandom); in_word = 1'($urandom); in_fld = 20'($urandom);
      q.push_back(model(in_valid, in_mode, in_base, in_imm_sz, in_word, in_fld,
                        reg_a0, reg_a1, reg_sb, reg_fb, reg_sp));
    end
    req(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    if (q.size() > 0) cmp(q.pop_front());
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: got hung expected completion");
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule